// File: doc/BRIEF.md
# Local External Interrupt Priority Controller

This block is the interrupt controller that sits beside one processor. It keeps a pending bit and an in-service bit for each of 256 external interrupt vectors. It decides which pending vector may be taken, using three things: a task-priority register, the vectors already in service, and a fixed priority order in which a higher vector number wins. The vector's priority class is its upper four bits.

Interrupt sources raise a vector through a one-cycle assert strobe. The core sees `irq_req` whenever some pending vector can be delivered. Software then reads the vector register, which returns the winning vector and moves it from pending to in-service in the same clock. When the handler finishes, software writes the end-of-interrupt register. That write retires the highest in-service vector, so lower-class pending vectors can get through again. Nothing leaves the block on an end-of-interrupt.

The register port is a single-cycle access with `reg_sel` encoded as follows: 0 = task priority, 1 = interrupt vector, 2 = end of interrupt, 3 = unused. Read data is combinational in the access cycle. State changes at the closing clock edge.

Top module: `lpic_top`

## Requirements
- R1: With the global mask clear, a vector 16..255 is masked when its class (vector[7:4]) is less than or equal to the class threshold held in task-priority bits 7:4. A threshold of 0 masks none of them, and a threshold of 15 masks all of them.
- R2: When task-priority bit 16 is 1, every vector except vector 2 is masked.
- R3: Vectors 0..15, including 0 and 2, are never masked by the class threshold.
- R4: A pending vector is blocked while any vector is in service and its class is less than or equal to the class of the highest in-service vector.
- R5: A read of the vector register (sel 1) returns the highest-numbered deliverable vector. At the closing edge it clears that vector's pending bit and sets its in-service bit.
- R6: A vector-register read with nothing deliverable returns 15 and leaves all pending and in-service bits unchanged.
- R7: Any write to the end-of-interrupt register (sel 2) clears the highest in-service vector, whatever the write data. The next-highest in-service vector, if any, then does the blocking.
- R8: Reads of the end-of-interrupt register, and of the unused select 3, return 0.
- R9: The task-priority register (sel 0) reads back the threshold in bits 7:4 and the global mask in bit 16. All other bits read 0 and ignore writes.
- R10: `irq_req` is 1 exactly when at least one pending vector is deliverable under the current masks and in-service state.
- R11: An assert strobe sets the pending bit of `vec_num`. Reset clears all pending bits, all in-service bits and the task-priority register.
- R12: If the vector being taken by a vector-register read is asserted again in the same cycle, it stays pending and also becomes in-service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_valid | input | 1 | Assert strobe for one external vector |
| vec_num | input | 8 | Vector number being asserted |
| reg_en | input | 1 | Register access in this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | 0 task priority, 1 interrupt vector, 2 end of interrupt, 3 unused |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid in the access cycle |
| irq_req | output | 1 | Some pending vector is deliverable |

## Verification
The hardest states to reach are stacked in-service vectors of different classes, with lower-class vectors held pending behind them. They matter because each end-of-interrupt must hand the blocking role to the next in-service vector rather than release everything. Directed sequences build such stacks on purpose: several classes are taken in turn, an end-of-interrupt is issued with all-ones data, and the bench checks that the same-class vector stays blocked until the second retirement. Long random runs mix asserts, vector reads, end-of-interrupt writes and threshold writes, so deeper stacks and the global-mask cases recur, and a bench model predicts every read value and `irq_req`.

// File: rtl/lpic_pkg.sv
package lpic_pkg;

    typedef enum logic [1:0] {
        SEL_TPR  = 2'd0,
        SEL_IVR  = 2'd1,
        SEL_EOI  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/lpic_prio_enc.sv
module lpic_prio_enc #(
    parameter int N     = 256,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // highest set index wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lpic_mask.sv
module lpic_mask #(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4,
    parameter int NMI_VEC = 2
) (
    input  logic [CLASS_W-1:0]     thresh,
    input  logic                   gmask,
    output logic [(1<<VEC_W)-1:0]  allow
);

    localparam int NUM_VEC = 1 << VEC_W;
    localparam int CLS_SH  = VEC_W - CLASS_W;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        localparam logic [CLASS_W-1:0] VCLS = CLASS_W'(v >> CLS_SH);
        if (v == NMI_VEC) begin : g_nmi
            assign allow[v] = 1'b1;
        end else if (VCLS == '0) begin : g_low
            assign allow[v] = ~gmask;
        end else begin : g_cls
            assign allow[v] = ~gmask & (VCLS > thresh);
        end
    end

endmodule

// File: rtl/lpic_top.sv
module lpic_top #(
    parameter int VEC_W    = 8,
    parameter int CLASS_W  = 4,
    parameter int DATA_W   = 64,
    parameter int SPURIOUS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec_num,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req
);
    import lpic_pkg::*;

    localparam int NUM_VEC = 1 << VEC_W;
    localparam int MIC_LSB = 4;
    localparam int MMI_BIT = 16;
    localparam int CLS_SH  = VEC_W - CLASS_W;

    typedef struct packed {
        logic [NUM_VEC-1:0] pend;
        logic [NUM_VEC-1:0] insvc;
        logic [CLASS_W-1:0] mic;
        logic               mmi;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_VEC-1:0] allow;
    logic [NUM_VEC-1:0] deliver;
    logic               isv_any, dlv_any;
    logic [VEC_W-1:0]   hi_isv, hi_dlv;
    logic [CLASS_W-1:0] isv_cls;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata;

    lpic_mask #(.VEC_W(VEC_W), .CLASS_W(CLASS_W), .NMI_VEC(2)) u_mask (
        .thresh (st_q.mic),
        .gmask  (st_q.mmi),
        .allow  (allow)
    );

    lpic_prio_enc #(.N(NUM_VEC), .IDX_W(VEC_W)) u_isv_enc (
        .req (st_q.insvc),
        .any (isv_any),
        .idx (hi_isv)
    );

    assign isv_cls = hi_isv[VEC_W-1 -: CLASS_W];

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_dlv
        localparam logic [CLASS_W-1:0] VCLS = CLASS_W'(v >> CLS_SH);
        assign deliver[v] = st_q.pend[v] & allow[v] & (~isv_any | (VCLS > isv_cls));
    end

    lpic_prio_enc #(.N(NUM_VEC), .IDX_W(VEC_W)) u_dlv_enc (
        .req (deliver),
        .any (dlv_any),
        .idx (hi_dlv)
    );

    assign irq_req = dlv_any;

    always_comb begin
        reg_sel_e sel;
        logic     rd, wr;
        sel  = reg_sel_e'(reg_sel);
        rd   = reg_en & ~reg_we;
        wr   = reg_en & reg_we;
        st_d = st_q;

        if (rd && sel == SEL_IVR && dlv_any) begin
            st_d.pend[hi_dlv]  = 1'b0;
            st_d.insvc[hi_dlv] = 1'b1;
        end
        if (wr && sel == SEL_EOI && isv_any) begin
            st_d.insvc[hi_isv] = 1'b0;
        end
        if (wr && sel == SEL_TPR) begin
            st_d.mic = reg_wdata[MIC_LSB +: CLASS_W];
            st_d.mmi = reg_wdata[MMI_BIT];
        end
        if (vec_valid) begin
            st_d.pend[vec_num] = 1'b1;
        end

        reg_rdata = '0;
        case (sel)
            SEL_TPR: begin
                reg_rdata[MIC_LSB +: CLASS_W] = st_q.mic;
                reg_rdata[MMI_BIT]            = st_q.mmi;
            end
            SEL_IVR: reg_rdata = dlv_any ? DATA_W'(hi_dlv) : DATA_W'(SPURIOUS);
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lpic_checker.sv
module lpic_checker #(
    parameter int NUM_VEC  = 256,
    parameter int DATA_W   = 64,
    parameter int SPURIOUS = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_en,
    input logic               reg_we,
    input logic [1:0]         reg_sel,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               irq_req,
    input logic               mmi,
    input logic [NUM_VEC-1:0] insvc
);
    logic ivr_rd, eoi_wr, tpr_rd, zero_rd;
    assign ivr_rd  = reg_en && !reg_we && reg_sel == 2'd1;
    assign eoi_wr  = reg_en &&  reg_we && reg_sel == 2'd2;
    assign tpr_rd  = reg_en && !reg_we && reg_sel == 2'd0;
    assign zero_rd = reg_en && !reg_we && reg_sel[1];

    assert_eoi_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_rd |-> reg_rdata == '0);

    assert_tpr_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_rd |-> (reg_rdata & ~DATA_W'(64'h1_00F0)) == '0);

    assert_spurious_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && !irq_req) |-> reg_rdata == DATA_W'(SPURIOUS));

    assert_spurious_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && !irq_req && !eoi_wr) |=> $stable(insvc));

    assert_take_adds_insvc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && irq_req) |=> $countones(insvc) == $past($countones(insvc)) + 1);

    assert_eoi_retires_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && insvc != '0) |=> $countones(insvc) == $past($countones(insvc)) - 1);

    assert_gmask_only_nmi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_rd && irq_req && mmi) |-> reg_rdata == DATA_W'(2));

endmodule

bind lpic_top lpic_checker #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W), .SPURIOUS(SPURIOUS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .irq_req   (irq_req),
    .mmi       (st_q.mmi),
    .insvc     (st_q.insvc)
);

// File: tb/tb_lpic_top.sv
module tb_lpic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_valid = 1'b0;
    logic [7:0]  vec_num = '0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq_req;

    int checks = 0;
    int fails  = 0;

    bit m_pend [256];
    bit m_isv  [256];
    int m_mic;
    bit m_mmi;

    always #2 clk = ~clk;

    lpic_top dut (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_num(vec_num),
        .reg_en(reg_en), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    function automatic bit allowed(int v);
        if (m_mmi) return v == 2;
        if (v < 16) return 1'b1;
        return (v >> 4) > m_mic;
    endfunction

    function automatic int top_isv();
        for (int v = 255; v >= 0; v--) if (m_isv[v]) return v;
        return -1;
    endfunction

    function automatic int best();
        int h;
        h = top_isv();
        for (int v = 255; v >= 0; v--)
            if (m_pend[v] && allowed(v) && (h < 0 || (v >> 4) > (h >> 4))) return v;
        return -1;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic op(bit ve, int v, bit en, bit we, int sel, logic [63:0] wd, string req);
        int b;
        longint exp;
        @(negedge clk);
        vec_valid = ve; vec_num = 8'(v);
        reg_en = en; reg_we = we; reg_sel = 2'(sel); reg_wdata = wd;
        #1;
        b = best();
        chk(irq_req == (b >= 0), {req, "/R10 irq"}, irq_req, b >= 0);
        if (en && !we) begin
            case (sel)
                0: begin exp = (longint'(m_mmi) << 16) | (longint'(m_mic) << 4);
                         chk(reg_rdata == exp, "R9 tpr read", reg_rdata, exp); end
                1: begin exp = (b >= 0) ? b : 15;
                         chk(reg_rdata == exp, b >= 0 ? req : "R6", reg_rdata, exp); end
                default: chk(reg_rdata == 0, "R8 zero read", reg_rdata, 0);
            endcase
        end
        @(posedge clk);
        if (en && !we && sel == 1 && b >= 0) begin m_pend[b] = 0; m_isv[b] = 1; end
        if (en && we && sel == 2 && top_isv() >= 0) m_isv[top_isv()] = 0;
        if (en && we && sel == 0) begin m_mic = int'(wd[7:4]); m_mmi = wd[16]; end
        if (ve) m_pend[v] = 1;
    endtask

    task automatic assert_v(int v);            op(1, v, 0, 0, 0, 0, "R11"); endtask
    task automatic rd_ivr(string req);          op(0, 0, 1, 0, 1, 0, req);   endtask
    task automatic eoi(logic [63:0] d);         op(0, 0, 1, 1, 2, d, "R7");  endtask
    task automatic tpr_wr(logic [63:0] d);      op(0, 0, 1, 1, 0, d, "R9");  endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_mic = 0; m_mmi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11 reset state
        op(0, 0, 1, 0, 0, 0, "R11");
        rd_ivr("R11");
        op(0, 0, 1, 0, 2, 0, "R8");
        op(0, 0, 1, 0, 3, 0, "R8");

        // R1 class threshold
        tpr_wr(64'h40);
        assert_v(8'h45);
        rd_ivr("R1");
        assert_v(8'h50);
        rd_ivr("R1");
        eoi(0);
        tpr_wr(64'h0);
        rd_ivr("R1");
        eoi(0);

        // R3 low vectors unaffected by threshold
        tpr_wr(64'hF0);
        assert_v(2); assert_v(0); assert_v(9);
        assert_v(8'hFF);
        rd_ivr("R3"); eoi(0);
        rd_ivr("R3"); eoi(0);
        rd_ivr("R3"); eoi(0);
        rd_ivr("R3");

        // R2 global mask
        tpr_wr(64'hFFFF_0000_0001_0000);
        assert_v(8'hF0); assert_v(5); assert_v(2);
        rd_ivr("R2");
        rd_ivr("R2");
        eoi(64'hDEAD);
        tpr_wr(0);
        rd_ivr("R2"); eoi(0);
        rd_ivr("R2"); eoi(0);
        rd_ivr("R2"); eoi(0);

        // R4 / R7 in-service blocking and stacked retirement
        assert_v(8'h35); rd_ivr("R5");
        assert_v(8'h31); rd_ivr("R4");
        assert_v(8'h80); rd_ivr("R4");
        eoi(64'hFFFF_FFFF_FFFF_FFFF);
        rd_ivr("R7");
        eoi(0);
        rd_ivr("R7");
        eoi(0);

        // R12 re-assert of the vector being taken
        assert_v(8'h60);
        op(1, 8'h60, 1, 0, 1, 0, "R12");
        rd_ivr("R12");
        eoi(0);
        rd_ivr("R12");
        eoi(0);

        // R9 reserved bits
        tpr_wr(64'hFFFF_FFFF_FFFF_FFFF);
        op(0, 0, 1, 0, 0, 0, "R9");
        tpr_wr(64'hFFFF_FFFF_FFFE_FF0F);
        op(0, 0, 1, 0, 0, 0, "R9");
        tpr_wr(0);

        // random mix
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 3000; i++) begin
            int k;
            logic [63:0] d;
            k = $urandom_range(0, 99);
            d = {$urandom, $urandom};
            if (k < 35)      op(1, $urandom_range(0, 255), 0, 0, 0, 0, "R11");
            else if (k < 60) op($urandom_range(0, 3) == 0, $urandom_range(0, 255), 1, 0, 1, 0, "R5");
            else if (k < 80) op($urandom_range(0, 3) == 0, $urandom_range(0, 255), 1, 1, 2, d, "R7");
            else if (k < 88) op(0, 0, 1, 1, 0, (d & ~64'h1_0000) | (($urandom_range(0, 7) == 0) ? 64'h1_0000 : 64'h0), "R9");
            else if (k < 94) op(0, 0, 1, 0, 0, 0, "R9");
            else             op(0, 0, 1, 0, 2 + $urandom_range(0, 1), 0, "R8");
        end

        @(negedge clk);
        vec_valid = 0; reg_en = 0;
        finish_run();
    end

endmodule